// File: doc/BRIEF.md
# TPM Locality Register Space

This block is the byte-wide register file of a TPM interface, placed between a host bus front end and the command/response buffer. Each access carries a 16-bit address whose upper nibble names a locality (0 to 4) and whose lower twelve bits select a register inside that locality's window. Reads come back in the same cycle as the address, so a front end on a continuous clock needs no wait states. Writes are taken on the rising clock edge when the write enable is high.

The block keeps track of which locality owns the interface. A locality can request it, give it up, or take it from a lower locality. It also runs a short command state machine: idle, ready, receiving, executing and complete. While a command is executing, a processor sees a non-zero operation code. The processor reports completion on a strobe, and the block then raises a host interrupt if that interrupt is enabled. The reset is asynchronous and active low, because the bus clock only runs while a transfer is in progress.

Register offsets within a window: access 0x000, interrupt enable 0x008, interrupt vector 0x00C, interrupt status 0x010, status 0x018, data port 0x024, identity 0xF00.

Top module: `tpm_locality_regs`

## Requirements
- R1: After reset no locality is active and no request is pending. The access register reads 0x80, interrupt enable, interrupt vector and interrupt status read 0x00, opCode is 0 and hostIrq is 0.
- R2: The following read as 0xFF and ignore writes: any offset that is not listed, and any address whose locality nibble is 5 or above. This includes access requests made from localities 5 and above.
- R3: The identity register at 0xF00 reads the constant 0xA7, and writing it leaves that value unchanged.
- R4: Writing 1 to access bit 1 while no locality is active makes the writer active. A locality sees its own access register read with bit 5 set while it is active, and with bit 5 clear otherwise.
- R5: A request (access bit 1) made while another locality is active sets that locality's pending flag, which reads as access bit 2. When the active locality writes 1 to access bit 5, it gives up ownership, and the highest pending locality becomes active with its pending flag cleared. If nothing is pending, no locality remains active.
- R6: Writing 1 to access bit 3 seizes the interface, but only when the writer's locality number is higher than that of the active locality. Otherwise the write is ignored.
- R7: A write to the interrupt vector (low 4 bits, also driven on irqVector) changes it only when it comes from the active locality. It is ignored from any other locality, and when no locality is active.
- R8: The status register reads 0xFF from any locality that is not active. Writing 1 to status bit 6 from the active locality moves the machine from idle (or from complete, or back from ready or receiving) to ready, where status reads 0x80.
- R9: In ready or receiving, a write to the data port counts one byte. The first byte of a command is also taken as the command's total length. Status bit 3 stays set while fewer bytes than that length have arrived. Writing status bit 5 (go) moves the machine to executing only once the count has been met, and opCode then reads 1. It reads 0 in every other state.
- R10: A cmdDone pulse during execution moves the machine to complete. opCode returns to 0, status reads 0x10, and interrupt status bit 0 is set.
- R11: hostIrq is high exactly when interrupt enable bit 7 (global), interrupt enable bit 0 and interrupt status bit 0 are all set. Status bit 0 is cleared by the active locality writing 1 to it. A clear attempt from another locality leaves hostIrq high.
- R12: rdData reflects the addressed register in the same cycle. A written value appears on rdData in the cycle after its write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkHost | input | 1 | Host bus clock, may stop between transfers |
| resetN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Locality nibble and register offset |
| wrEn | input | 1 | Write strobe, sampled on the rising edge |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data for busAddr, same cycle |
| cmdDone | input | 1 | Completion strobe from the processor |
| opCode | output | 4 | Operation requested from the processor, 0 when none |
| hostIrq | output | 1 | Host interrupt request |
| irqVector | output | 4 | Interrupt vector value |

## Verification
The bench covers the edges of locality ownership in turn. These are a request that arrives while another locality is active, seizes from both a lower and a higher locality, and a chain of relinquishes that must grant the pending localities from highest to lowest. A design that granted the lowest pending locality, or that let a lower locality seize, reads back the wrong access byte. Interrupt vector and interrupt status writes are tried from a locality that does not own the interface; a design that missed the ownership check changes irqVector or drops hostIrq. A go that arrives before the declared byte count has been met must leave opCode at 0. An early transition shows up as opCode reading 1 too soon.

// File: rtl/tpm_regs_pkg.sv
package tpm_regs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READY, ST_RECV, ST_EXEC, ST_DONE
  } cmdState_t;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ACCESS, SEL_INTEN, SEL_INTVEC,
    SEL_INTSTS, SEL_STATUS, SEL_FIFO, SEL_ID
  } regSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrIntEn;
    logic wrIntVec;
    logic clrIntSts;
    logic setIntSts;
    logic fifoWr;
    logic clrCount;
  } dpStrobe_t;

  localparam logic [11:0] OFF_ACCESS = 12'h000;
  localparam logic [11:0] OFF_INTEN  = 12'h008;
  localparam logic [11:0] OFF_INTVEC = 12'h00C;
  localparam logic [11:0] OFF_INTSTS = 12'h010;
  localparam logic [11:0] OFF_STATUS = 12'h018;
  localparam logic [11:0] OFF_FIFO   = 12'h024;
  localparam logic [11:0] OFF_ID     = 12'hF00;

  // access register bits
  localparam int ACC_REQ_BIT    = 1;
  localparam int ACC_PEND_BIT   = 2;
  localparam int ACC_SEIZE_BIT  = 3;
  localparam int ACC_ACTIVE_BIT = 5;
  localparam int ACC_VALID_BIT  = 7;

  // status register bits
  localparam int STS_EXPECT_BIT = 3;
  localparam int STS_AVAIL_BIT  = 4;
  localparam int STS_GO_BIT     = 5;
  localparam int STS_RDYCMD_BIT = 6;
  localparam int STS_READY_BIT  = 7;

endpackage

// File: rtl/tpm_regs_ctrl.sv
module tpm_regs_ctrl
  import tpm_regs_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter logic [3:0] OP_EXECUTE = 4'd1
) (
  input  logic        clkHost,
  input  logic        resetN,
  input  logic [15:0] busAddr,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  input  logic        cmdDone,
  input  logic        countMet,
  output dpStrobe_t   strobe,
  output regSel_t     regSel,
  output logic [7:0]  accessByte,
  output logic [7:0]  statusByte,
  output logic [3:0]  opCode
);

  localparam int LOC_W = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1;
  localparam logic [3:0] LOC_LIMIT = 4'(NUM_LOC);

  logic [3:0]       locField;
  logic [11:0]      offset;
  logic             locValid;
  logic [LOC_W-1:0] locNum;

  logic             activeValid;
  logic [LOC_W-1:0] activeLoc;
  logic [NUM_LOC-1:0] pending;
  logic [LOC_W-1:0] topPend;
  logic             anyPend;
  logic             hitActive;
  logic             accessWr;
  logic             statusWr;

  cmdState_t state, stateNext;

  assign locField = busAddr[15:12];
  assign offset   = busAddr[11:0];
  assign locValid = locField < LOC_LIMIT;
  assign locNum   = locField[LOC_W-1:0];

  always_comb begin
    regSel = SEL_NONE;
    if (locValid) begin
      case (offset)
        OFF_ACCESS: regSel = SEL_ACCESS;
        OFF_INTEN:  regSel = SEL_INTEN;
        OFF_INTVEC: regSel = SEL_INTVEC;
        OFF_INTSTS: regSel = SEL_INTSTS;
        OFF_STATUS: regSel = SEL_STATUS;
        OFF_FIFO:   regSel = SEL_FIFO;
        OFF_ID:     regSel = SEL_ID;
        default:    regSel = SEL_NONE;
      endcase
    end
  end

  assign hitActive = locValid && activeValid && (activeLoc == locNum);
  assign accessWr  = wrEn && (regSel == SEL_ACCESS);
  assign statusWr  = wrEn && (regSel == SEL_STATUS) && hitActive;

  // highest pending locality
  always_comb begin
    topPend = '0;
    anyPend = |pending;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (pending[i]) topPend = LOC_W'(i);
    end
  end

  always_ff @(posedge clkHost or negedge resetN) begin
    if (!resetN) begin
      activeValid <= 1'b0;
      activeLoc   <= '0;
      pending     <= '0;
    end else if (accessWr) begin
      if (wrData[ACC_ACTIVE_BIT] && hitActive) begin
        if (anyPend) begin
          activeLoc        <= topPend;
          pending[topPend] <= 1'b0;
        end else begin
          activeValid <= 1'b0;
        end
      end else if (wrData[ACC_SEIZE_BIT] && activeValid && (locNum > activeLoc)) begin
        activeLoc       <= locNum;
        pending[locNum] <= 1'b0;
      end else if (wrData[ACC_REQ_BIT]) begin
        if (!activeValid) begin
          activeValid <= 1'b1;
          activeLoc   <= locNum;
        end else if (!hitActive) begin
          pending[locNum] <= 1'b1;
        end
      end
    end
  end

  // command state machine
  always_comb begin
    stateNext = state;
    if (statusWr && wrData[STS_RDYCMD_BIT] && (state != ST_EXEC)) begin
      stateNext = ST_READY;
    end else begin
      case (state)
        ST_READY: if (strobe.fifoWr) stateNext = ST_RECV;
        ST_RECV:  if (statusWr && wrData[STS_GO_BIT] && countMet) stateNext = ST_EXEC;
        ST_EXEC:  if (cmdDone) stateNext = ST_DONE;
        default:  stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clkHost or negedge resetN) begin
    if (!resetN) state <= ST_IDLE;
    else         state <= stateNext;
  end

  always_comb begin
    strobe           = '0;
    strobe.wrIntEn   = wrEn && (regSel == SEL_INTEN)  && hitActive;
    strobe.wrIntVec  = wrEn && (regSel == SEL_INTVEC) && hitActive;
    strobe.clrIntSts = wrEn && (regSel == SEL_INTSTS) && hitActive;
    strobe.fifoWr    = wrEn && (regSel == SEL_FIFO) && hitActive &&
                       ((state == ST_READY) || (state == ST_RECV));
    strobe.setIntSts = cmdDone && (state == ST_EXEC);
    strobe.clrCount  = (stateNext == ST_READY) && (state != ST_RECV || statusWr);
  end

  always_comb begin
    accessByte = '0;
    accessByte[ACC_VALID_BIT]  = 1'b1;
    accessByte[ACC_ACTIVE_BIT] = hitActive;
    accessByte[ACC_PEND_BIT]   = locValid && pending[locNum];
  end

  always_comb begin
    if (!hitActive) begin
      statusByte = 8'hFF;
    end else begin
      statusByte = '0;
      statusByte[STS_READY_BIT]  = (state == ST_READY);
      statusByte[STS_AVAIL_BIT]  = (state == ST_DONE);
      statusByte[STS_EXPECT_BIT] = (state == ST_RECV) && !countMet;
    end
  end

  assign opCode = (state == ST_EXEC) ? OP_EXECUTE : 4'd0;

  logic unusedOk;
  assign unusedOk = ^{wrData[7], wrData[4], wrData[2], wrData[0]};

endmodule

// File: rtl/tpm_regs_datapath.sv
module tpm_regs_datapath
  import tpm_regs_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int VEC_W = 4,
  parameter logic [7:0] ID_VALUE = 8'hA7
) (
  input  logic             clkHost,
  input  logic             resetN,
  input  dpStrobe_t        strobe,
  input  regSel_t          regSel,
  input  logic [7:0]       wrData,
  input  logic [7:0]       accessByte,
  input  logic [7:0]       statusByte,
  output logic [7:0]       rdData,
  output logic             countMet,
  output logic             hostIrq,
  output logic [VEC_W-1:0] irqVector
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             intEnGlobal;
  logic             intEnDone;
  logic [VEC_W-1:0] intVec;
  logic             intStsDone;
  logic [CNT_W-1:0] byteCount;
  logic [CNT_W-1:0] expLen;

  always_ff @(posedge clkHost or negedge resetN) begin
    if (!resetN) begin
      intEnGlobal <= 1'b0;
      intEnDone   <= 1'b0;
      intVec      <= '0;
      intStsDone  <= 1'b0;
    end else begin
      if (strobe.wrIntEn) begin
        intEnGlobal <= wrData[7];
        intEnDone   <= wrData[0];
      end
      if (strobe.wrIntVec) intVec <= wrData[VEC_W-1:0];
      if (strobe.setIntSts)                    intStsDone <= 1'b1;
      else if (strobe.clrIntSts && wrData[0])  intStsDone <= 1'b0;
    end
  end

  always_ff @(posedge clkHost or negedge resetN) begin
    if (!resetN) begin
      byteCount <= '0;
      expLen    <= '0;
    end else if (strobe.clrCount) begin
      byteCount <= '0;
      expLen    <= '0;
    end else if (strobe.fifoWr) begin
      if (byteCount == '0) expLen <= CNT_W'(wrData);
      if (byteCount != CNT_MAX) byteCount <= byteCount + 1'b1;
    end
  end

  assign countMet  = (expLen != '0) && (byteCount >= expLen);
  assign hostIrq   = intEnGlobal && intEnDone && intStsDone;
  assign irqVector = intVec;

  always_comb begin
    case (regSel)
      SEL_ACCESS: rdData = accessByte;
      SEL_INTEN:  rdData = {intEnGlobal, 6'b0, intEnDone};
      SEL_INTVEC: rdData = 8'(intVec);
      SEL_INTSTS: rdData = {7'b0, intStsDone};
      SEL_STATUS: rdData = statusByte;
      SEL_FIFO:   rdData = 8'h00;
      SEL_ID:     rdData = ID_VALUE;
      default:    rdData = 8'hFF;
    endcase
  end

  logic unusedOk;
  assign unusedOk = ^wrData;

endmodule

// File: rtl/tpm_locality_regs.sv
module tpm_locality_regs
  import tpm_regs_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int CNT_W = 8,
  parameter logic [7:0] ID_VALUE = 8'hA7
) (
  input  logic        clkHost,
  input  logic        resetN,
  input  logic [15:0] busAddr,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic        cmdDone,
  output logic [3:0]  opCode,
  output logic        hostIrq,
  output logic [3:0]  irqVector
);

  dpStrobe_t  strobe;
  regSel_t    regSel;
  logic [7:0] accessByte;
  logic [7:0] statusByte;
  logic       countMet;

  tpm_regs_ctrl #(.NUM_LOC(NUM_LOC), .OP_EXECUTE(4'd1)) ctrl (
    .clkHost(clkHost), .resetN(resetN), .busAddr(busAddr), .wrEn(wrEn),
    .wrData(wrData), .cmdDone(cmdDone), .countMet(countMet),
    .strobe(strobe), .regSel(regSel), .accessByte(accessByte),
    .statusByte(statusByte), .opCode(opCode)
  );

  tpm_regs_datapath #(.CNT_W(CNT_W), .VEC_W(4), .ID_VALUE(ID_VALUE)) dp (
    .clkHost(clkHost), .resetN(resetN), .strobe(strobe), .regSel(regSel),
    .wrData(wrData), .accessByte(accessByte), .statusByte(statusByte),
    .rdData(rdData), .countMet(countMet), .hostIrq(hostIrq),
    .irqVector(irqVector)
  );

endmodule

// File: rtl/tpm_locality_regs_checker.sv
module tpm_locality_regs_checker #(
  parameter int NUM_LOC = 5
) (
  input logic        clkHost,
  input logic        resetN,
  input logic [15:0] busAddr,
  input logic        wrEn,
  input logic [7:0]  rdData,
  input logic        cmdDone,
  input logic [3:0]  opCode,
  input logic        hostIrq,
  input logic [3:0]  irqVector
);

  localparam logic [3:0] LOC_LIMIT = 4'(NUM_LOC);

  assert_no_locality_R2: assert property (@(posedge clkHost) disable iff (!resetN)
    (busAddr[15:12] >= LOC_LIMIT) |-> (rdData == 8'hFF));

  assert_vector_needs_write_R7: assert property (@(posedge clkHost) disable iff (!resetN)
    !wrEn |=> $stable(irqVector));

  assert_opcode_legal_R9: assert property (@(posedge clkHost) disable iff (!resetN)
    (opCode == 4'd0) || (opCode == 4'd1));

  assert_exec_from_write_R9: assert property (@(posedge clkHost) disable iff (!resetN)
    $rose(opCode != 4'd0) |-> $past(wrEn));

  assert_opcode_clears_R10: assert property (@(posedge clkHost) disable iff (!resetN)
    (opCode != 4'd0) && cmdDone |=> (opCode == 4'd0));

  assert_irq_holds_R11: assert property (@(posedge clkHost) disable iff (!resetN)
    hostIrq && !wrEn |=> hostIrq);

endmodule

bind tpm_locality_regs tpm_locality_regs_checker #(.NUM_LOC(NUM_LOC)) checker_i (
  .clkHost(clkHost), .resetN(resetN), .busAddr(busAddr), .wrEn(wrEn),
  .rdData(rdData), .cmdDone(cmdDone), .opCode(opCode), .hostIrq(hostIrq),
  .irqVector(irqVector)
);

// File: tb/tpm_locality_regs_test.sv
module tpm_locality_regs_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  localparam logic [11:0] ACC = 12'h000, IEN = 12'h008, VEC = 12'h00C,
                          IST = 12'h010, STS = 12'h018, DAT = 12'h024, IDR = 12'hF00;

  logic        clkHost = 1'b0;
  logic        resetN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        cmdDone = 1'b0;
  logic [3:0]  opCode;
  logic        hostIrq;
  logic [3:0]  irqVector;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    int         kind;   // 0 rdData, 1 opCode, 2 hostIrq, 3 irqVector
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t expQ[$];

  tpm_locality_regs uut (
    .clkHost(clkHost), .resetN(resetN), .busAddr(busAddr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .cmdDone(cmdDone), .opCode(opCode),
    .hostIrq(hostIrq), .irqVector(irqVector)
  );

  always #(CLK_PERIOD/2) clkHost = ~clkHost;

  function automatic logic [15:0] at(input int loc, input logic [11:0] off);
    return {4'(loc), off};
  endfunction

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    @(negedge clkHost);
    busAddr = a; wrEn = 1'b0; cmdDone = 1'b0;
    expQ.push_back('{0, e, tag});
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clkHost);
    busAddr = a; wrData = d; wrEn = 1'b1; cmdDone = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clkHost);
    wrEn = 1'b0; cmdDone = 1'b1;
  endtask

  task automatic port(input int kind, input logic [7:0] e, input string tag);
    @(negedge clkHost);
    wrEn = 1'b0; cmdDone = 1'b0;
    expQ.push_back('{kind, e, tag});
  endtask

  // monitor: compares results a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clkHost);
      #(CLK_PERIOD/4);
      while (expQ.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = expQ.pop_front();
        case (it.kind)
          0: act = rdData;
          1: act = 8'(opCode);
          2: act = 8'(hostIrq);
          default: act = 8'(irqVector);
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s actual=%0h expected=%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clkHost);
    if (!finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clkHost);
    resetN = 1'b1;

    // R1 reset state
    rd(at(0, ACC), 8'h80, "R1 access");
    rd(at(0, STS), 8'hFF, "R1 status no owner");
    rd(at(0, IEN), 8'h00, "R1 int enable");
    rd(at(0, VEC), 8'h00, "R1 vector");
    rd(at(0, IST), 8'h00, "R1 int status");
    port(1, 8'h0, "R1 opCode");
    port(2, 8'h0, "R1 hostIrq");

    // R2 undefined space
    rd(at(0, 12'h004), 8'hFF, "R2 undefined read");
    wr(at(0, 12'h004), 8'h12);
    rd(at(0, 12'h004), 8'hFF, "R2 undefined after write");
    rd(at(5, ACC), 8'hFF, "R2 locality 5 read");
    wr(at(5, ACC), 8'h02);
    rd(at(0, ACC), 8'h80, "R2 locality 5 request ignored");
    rd(at(7, ACC), 8'hFF, "R2 locality 7 read");

    // R3 identity
    rd(at(0, IDR), 8'hA7, "R3 id");
    wr(at(0, IDR), 8'h00);
    rd(at(0, IDR), 8'hA7, "R3 id after write");

    // R7 vector write with no owner
    wr(at(0, VEC), 8'h05);
    rd(at(0, VEC), 8'h00, "R7 vector no owner");

    // R4 grant
    wr(at(1, ACC), 8'h02);
    rd(at(1, ACC), 8'hA0, "R4 loc1 active");
    rd(at(0, ACC), 8'h80, "R4 loc0 not active");

    // R5 pending
    wr(at(0, ACC), 8'h02);
    rd(at(0, ACC), 8'h84, "R5 loc0 pending");
    wr(at(2, ACC), 8'h02);
    rd(at(2, ACC), 8'h84, "R5 loc2 pending");

    // R7 ownership of vector
    wr(at(0, VEC), 8'h03);
    rd(at(0, VEC), 8'h00, "R7 vector from non-owner");
    wr(at(1, VEC), 8'h09);
    rd(at(1, VEC), 8'h09, "R12 vector visible next cycle");
    rd(at(3, VEC), 8'h09, "R7 vector read elsewhere");
    port(3, 8'h9, "R7 irqVector");

    // R6 seize
    wr(at(0, ACC), 8'h08);
    rd(at(1, ACC), 8'hA0, "R6 lower seize ignored");
    wr(at(3, ACC), 8'h08);
    rd(at(3, ACC), 8'hA0, "R6 loc3 seized");
    rd(at(1, ACC), 8'h80, "R6 loc1 lost");

    // R5 relinquish chain
    wr(at(3, ACC), 8'h20);
    rd(at(2, ACC), 8'hA0, "R5 highest pending granted");
    rd(at(0, ACC), 8'h84, "R5 loc0 still pending");
    wr(at(2, ACC), 8'h20);
    rd(at(0, ACC), 8'hA0, "R5 loc0 granted");

    // R8 status and command ready
    rd(at(1, STS), 8'hFF, "R8 status non-owner");
    rd(at(0, STS), 8'h00, "R8 status idle");
    wr(at(0, STS), 8'h40);
    rd(at(0, STS), 8'h80, "R8 ready");

    // R9 reception and go
    wr(at(0, DAT), 8'h03);
    rd(at(0, STS), 8'h08, "R9 expect");
    wr(at(0, STS), 8'h20);
    port(1, 8'h0, "R9 early go ignored");
    rd(at(0, STS), 8'h08, "R9 still expecting");
    wr(at(0, DAT), 8'hAA);
    wr(at(0, DAT), 8'hBB);
    rd(at(0, STS), 8'h00, "R9 count met");
    wr(at(0, STS), 8'h20);
    port(1, 8'h1, "R9 executing");

    // R11 enable interrupt
    wr(at(0, IEN), 8'h81);
    rd(at(0, IEN), 8'h81, "R11 enable readback");
    port(2, 8'h0, "R11 no irq before done");

    // R10 completion
    pulseDone();
    port(1, 8'h0, "R10 opCode cleared");
    rd(at(0, STS), 8'h10, "R10 data available");
    rd(at(0, IST), 8'h01, "R10 int status set");
    port(2, 8'h1, "R11 irq raised");

    // R11 clear rules
    wr(at(1, IST), 8'h01);
    port(2, 8'h1, "R11 non-owner clear ignored");
    wr(at(0, IST), 8'h01);
    port(2, 8'h0, "R11 irq cleared");
    rd(at(0, IST), 8'h00, "R11 status cleared");

    // R8 completion back to ready
    wr(at(0, STS), 8'h40);
    rd(at(0, STS), 8'h80, "R8 complete to ready");

    @(negedge clkHost);
    @(negedge clkHost);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule